// File: doc/BRIEF.md
# DMA Write Completion Handshake Controller

This block sits between the internal DMA write engine of a USB core and the logic that reports per-channel transfer completion. A transfer is made of one or more DMA writes to external memory. Each write is framed by a start strobe and an end strobe. The start strobe carries a flag that marks the final write of the transfer.

When the system-wait mode is enabled, a handshaked write raises a request line while it is in flight. When it ends, the block emits a one-cycle internal-done pulse. It then waits for the system to confirm that its own DMA path has drained. Only after that confirmation does the final write of the transfer produce the transfer-complete pulse. A second mode bit extends the handshake from the final write to every write of the transfer. That bit only counts when the wait mode is on. When the wait mode is off, no handshake signal is ever driven, and transfer-complete follows the end of the final write directly.

The controller is a four-state machine:
- IDLE: waiting for a write to start.
- WRITING: a write is in flight.
- WAIT_SYS: waiting for the system confirmation.
- COMPLETE: one cycle that emits transfer-complete.

The transitions are:
- IDLE to WRITING on a write start.
- WRITING to WAIT_SYS on a handshaked write end.
- WRITING to COMPLETE on an unhandshaked final write end.
- WRITING to IDLE on an unhandshaked intermediate write end.
- WAIT_SYS to COMPLETE on system-done after a final write.
- WAIT_SYS to IDLE on system-done after an intermediate write.
- COMPLETE to IDLE unconditionally.

The two mode bits are captured when the first write of a transfer starts. The captured values hold until the transfer completes.

Top module: `dma_wr_sync_ctrl`

## Requirements
- R1: After reset the controller is in IDLE, and `req_o`, `int_done_o` and `xfer_cmpl_o` are all 0.
- R2: For a handshaked write, `req_o` is 1 from the cycle after the accepted `wr_start` up to and including the cycle in which `wr_end` is sampled. It is 0 from the next cycle.
- R3: `int_done_o` is a single-cycle pulse in the cycle after a handshaked write's `wr_end` is sampled, and `req_o` is 0 in that cycle.
- R4: After a handshaked final write, `xfer_cmpl_o` stays 0 until `sys_done` is sampled in WAIT_SYS. It then rises in the following cycle.
- R5: With the captured wait mode at 0, `req_o` and `int_done_o` stay 0, and `xfer_cmpl_o` rises in the cycle after the final write's `wr_end` is sampled.
- R6: With the wait mode at 1 and the all-writes bit at 1, every write of the transfer is handshaked. With the wait mode at 0, the all-writes bit has no effect.
- R7: With the wait mode at 1 and the all-writes bit at 0, only the write started with `wr_last` = 1 is handshaked. An intermediate write returns to IDLE without any pulse.
- R8: `xfer_cmpl_o` is high for exactly one cycle per transfer, and the controller is back in IDLE in the next cycle.
- R9: `sys_done` has no effect in IDLE or WRITING: no transfer-complete and no state change result from it.
- R10: `cfg_wait_en` and `cfg_all_wr` are sampled at the first write start of a transfer. Changes during the transfer take effect on the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wait_en | input | 1 | Enable the wait for system DMA done |
| cfg_all_wr | input | 1 | Handshake every write, not only the final one (needs `cfg_wait_en`) |
| wr_start | input | 1 | One-cycle strobe: a DMA write begins |
| wr_last | input | 1 | Sampled with `wr_start`: 1 marks the final write of the transfer |
| wr_end | input | 1 | One-cycle strobe: the write finished at the core boundary |
| sys_done | input | 1 | System confirmation that its DMA writes have completed |
| req_o | output | 1 | Handshaked write in flight |
| int_done_o | output | 1 | One-cycle pulse: core-side write finished, awaiting system |
| xfer_cmpl_o | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions assume that the write engine frames its traffic correctly. `wr_start` comes only while no write is in flight, `wr_end` only after a matching start, and each strobe is a single cycle.

The stimulus keeps to this framing. It drives every strobe for exactly one cycle and never overlaps two writes. It sends `sys_done` out of turn only as a deliberate probe of R9, in IDLE and in WRITING, where the controller must ignore it.

// File: rtl/dma_wr_sync_pkg.sv
package dma_wr_sync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WRITING  = 2'd1,
        ST_WAIT_SYS = 2'd2,
        ST_COMPLETE = 2'd3
    } wr_state_e;

endpackage

// File: rtl/dma_wr_cfg_latch.sv
module dma_wr_cfg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wait_en,
    input  logic cfg_all_wr,
    input  logic capture,
    input  logic release_xfer,
    output logic open_o,
    output logic wait_q_o,
    output logic eff_wait_o,
    output logic eff_all_o
);

    logic wait_q;
    logic all_q;
    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= 1'b0;
            all_q  <= 1'b0;
            open_q <= 1'b0;
        end else if (capture) begin
            wait_q <= cfg_wait_en;
            all_q  <= cfg_wait_en & cfg_all_wr;
            open_q <= 1'b1;
        end else if (release_xfer) begin
            open_q <= 1'b0;
        end
    end

    // The first write of a transfer sees the live bits; later writes see the captured copy.
    always_comb begin
        if (capture) begin
            eff_wait_o = cfg_wait_en;
            eff_all_o  = cfg_wait_en & cfg_all_wr;
        end else begin
            eff_wait_o = wait_q;
            eff_all_o  = all_q;
        end
    end

    assign open_o   = open_q;
    assign wait_q_o = wait_q;

    // R10: the captured mode holds while a transfer is open
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !release_xfer) |=> ($stable(wait_q) && $stable(all_q)));

    // R6: the all-writes copy is never set without the wait copy
    p_all_needs_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        all_q |-> wait_q);

endmodule

// File: rtl/dma_wr_sync_fsm.sv
module dma_wr_sync_fsm
    import dma_wr_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_start,
    input  logic wr_last,
    input  logic wr_end,
    input  logic sys_done,
    input  logic open_i,
    input  logic eff_wait,
    input  logic eff_all,
    output logic capture_o,
    output logic release_o,
    output logic req_o,
    output logic int_done_o,
    output logic xfer_cmpl_o
);

    wr_state_e state_q, state_d;
    logic      hs_q;
    logic      last_q;
    logic      done_q;
    logic      start_ok;

    assign start_ok  = (state_q == ST_IDLE) && wr_start;
    assign capture_o = start_ok && !open_i;
    assign release_o = (state_q == ST_COMPLETE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start) state_d = ST_WRITING;
            end
            ST_WRITING: begin
                if (wr_end) begin
                    if (hs_q)        state_d = ST_WAIT_SYS;
                    else if (last_q) state_d = ST_COMPLETE;
                    else             state_d = ST_IDLE;
                end
            end
            ST_WAIT_SYS: begin
                if (sys_done) state_d = last_q ? ST_COMPLETE : ST_IDLE;
            end
            ST_COMPLETE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and per-write attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hs_q    <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                last_q <= wr_last;
                hs_q   <= eff_wait & (eff_all | wr_last);
            end
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_WRITING) && wr_end && hs_q;
    end

    assign req_o       = (state_q == ST_WRITING) && hs_q;
    assign int_done_o  = done_q;
    assign xfer_cmpl_o = (state_q == ST_COMPLETE);

    // R3: internal done is a lone pulse and never overlaps the request
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_done_o |=> !int_done_o);
    p_done_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_done_o |-> !req_o);
    // R4: no completion while the system has not answered
    p_hold_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SYS && !sys_done) |=> !xfer_cmpl_o);
    // R8: completion is a single-cycle pulse followed by IDLE
    p_cmpl_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cmpl_o |=> (!xfer_cmpl_o && state_q == ST_IDLE));
    // R9: from IDLE the next state is never COMPLETE
    p_idle_no_cmpl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !xfer_cmpl_o);
    // R2: request drops once the write has ended
    p_req_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && wr_end) |=> !req_o);

endmodule

// File: rtl/dma_wr_sync_ctrl.sv
module dma_wr_sync_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wait_en,
    input  logic cfg_all_wr,
    input  logic wr_start,
    input  logic wr_last,
    input  logic wr_end,
    input  logic sys_done,
    output logic req_o,
    output logic int_done_o,
    output logic xfer_cmpl_o
);

    logic capture;
    logic release_xfer;
    logic open_q;
    logic wait_q;
    logic eff_wait;
    logic eff_all;

    dma_wr_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wait_en (cfg_wait_en),
        .cfg_all_wr  (cfg_all_wr),
        .capture     (capture),
        .release_xfer(release_xfer),
        .open_o      (open_q),
        .wait_q_o    (wait_q),
        .eff_wait_o  (eff_wait),
        .eff_all_o   (eff_all)
    );

    dma_wr_sync_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .wr_last    (wr_last),
        .wr_end     (wr_end),
        .sys_done   (sys_done),
        .open_i     (open_q),
        .eff_wait   (eff_wait),
        .eff_all    (eff_all),
        .capture_o  (capture),
        .release_o  (release_xfer),
        .req_o      (req_o),
        .int_done_o (int_done_o),
        .xfer_cmpl_o(xfer_cmpl_o)
    );

    // R5: a transfer captured with wait mode off never drives the handshake
    p_off_no_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !wait_q) |-> (!req_o && !int_done_o));

endmodule

// File: tb/dma_wr_sync_ctrl_test.sv
module dma_wr_sync_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;
    localparam int NVEC       = 8;

    // Row fields: {wait, all, two_writes, hs_mid, hs_last}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b00_0_0_0, 5'b01_0_0_0, 5'b10_0_0_1, 5'b11_0_0_1,
        5'b00_1_0_0, 5'b10_1_0_1, 5'b11_1_1_1, 5'b01_1_0_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wait_en = 1'b0, cfg_all_wr = 1'b0;
    logic wr_start = 1'b0, wr_last = 1'b0, wr_end = 1'b0, sys_done = 1'b0;
    logic req_o, int_done_o, xfer_cmpl_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_wr_sync_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wait_en(cfg_wait_en), .cfg_all_wr(cfg_all_wr),
        .wr_start(wr_start), .wr_last(wr_last), .wr_end(wr_end), .sys_done(sys_done),
        .req_o(req_o), .int_done_o(int_done_o), .xfer_cmpl_o(xfer_cmpl_o)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One write: start, end, optional system handshake
    task automatic do_write(input logic last, input logic exp_hs);
        wr_start = 1'b1; wr_last = last;
        step();
        wr_start = 1'b0; wr_last = 1'b0;
        check("R2 req during write", req_o, exp_hs);
        if (!exp_hs) check("R5 no req when not handshaked", req_o, 1'b0);
        wr_end = 1'b1;
        step();
        wr_end = 1'b0;
        check("R3 int_done after end", int_done_o, exp_hs);
        check("R2 req low after end", req_o, 1'b0);
        check("R5/R7 cmpl after end", xfer_cmpl_o, !exp_hs && last);
        if (exp_hs) begin
            sys_done = 1'b1;
            step();
            sys_done = 1'b0;
            check("R3 int_done single cycle", int_done_o, 1'b0);
            check("R4 cmpl after sys_done", xfer_cmpl_o, last);
        end
        if (last) begin
            step();
            check("R8 cmpl single cycle", xfer_cmpl_o, 1'b0);
        end
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 req at reset", req_o, 1'b0);
        check("R1 int_done at reset", int_done_o, 1'b0);
        check("R1 cmpl at reset", xfer_cmpl_o, 1'b0);
        rst_n = 1'b1;
        step();

        // Table walk: R5, R6, R7
        for (int i = 0; i < NVEC; i++) begin
            cfg_wait_en = VEC[i][4];
            cfg_all_wr  = VEC[i][3];
            if (VEC[i][2]) do_write(1'b0, VEC[i][1]);
            do_write(1'b1, VEC[i][0]);
            step();
        end

        // R9: sys_done in IDLE is ignored
        cfg_wait_en = 1'b1; cfg_all_wr = 1'b0;
        sys_done = 1'b1;
        step();
        sys_done = 1'b0;
        check("R9 sys_done in IDLE", xfer_cmpl_o, 1'b0);
        check("R9 sys_done in IDLE req", req_o, 1'b0);

        // R9: sys_done in WRITING is ignored, R4: long wait holds completion
        wr_start = 1'b1; wr_last = 1'b1;
        step();
        wr_start = 1'b0; wr_last = 1'b0;
        sys_done = 1'b1;
        step();
        sys_done = 1'b0;
        check("R9 sys_done in WRITING keeps req", req_o, 1'b1);
        check("R9 sys_done in WRITING no cmpl", xfer_cmpl_o, 1'b0);
        wr_end = 1'b1;
        step();
        wr_end = 1'b0;
        check("R3 int_done", int_done_o, 1'b1);
        for (int k = 0; k < 6; k++) begin
            step();
            check("R4 held without sys_done", xfer_cmpl_o, 1'b0);
        end
        sys_done = 1'b1;
        step();
        sys_done = 1'b0;
        check("R4 cmpl after late sys_done", xfer_cmpl_o, 1'b1);
        step();
        check("R8 back to idle", xfer_cmpl_o, 1'b0);

        // R10: mode turned off mid-transfer still handshakes
        cfg_wait_en = 1'b1; cfg_all_wr = 1'b1;
        do_write(1'b0, 1'b1);
        cfg_wait_en = 1'b0; cfg_all_wr = 1'b0;
        do_write(1'b1, 1'b1);
        step();

        // R10: mode turned on mid-transfer has no effect
        do_write(1'b0, 1'b0);
        cfg_wait_en = 1'b1; cfg_all_wr = 1'b1;
        do_write(1'b1, 1'b0);
        step();

        // R10: the new mode applies to the next transfer
        do_write(1'b1, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule